// File: doc/BRIEF.md
# Integer Execute Unit with Immediates

This block is the execute stage for a small 32-bit RISC integer subset. Each cycle it can accept one instruction word, already fetched, together with the two source register values read for it. It decodes the word, extends the immediate in the way the operation needs, and computes the result. One cycle later it presents the result, the destination register number, a register write-enable, and flags that mark a memory load, a memory store or an unrecognised encoding.

Register-format words carry the opcode in bits 31:26, the first source register in bits 25:21, the second source register in bits 20:16, the destination in bits 15:11, a shift amount in bits 10:6 that is not used here, and a function code in bits 5:0. Immediate-format words keep the opcode and the two register fields in the same positions and hold a 16-bit immediate in bits 15:0. For these words the register in bits 20:16 is the destination. For load and store the block produces the effective address and nothing more. The register file, the data memory, overflow traps and multiply/divide are handled elsewhere.

Top module: `exu_core`

## Requirements
- R1: With opcode 0, function 32 gives a + b, function 34 gives a - b, and function 42 gives signed set-less-than. The destination is bits 15:11.
- R2: For immediate-format operations the destination is bits 20:16. Opcode 8 (add) and opcode 10 (set-less-than) sign-extend the 16-bit immediate. Opcode 12 (and) and opcode 13 (or) zero-extend it.
- R3: Set-less-than, from either format, produces 1 when the first operand is below the second in two's-complement order and 0 otherwise.
- R4: Opcode 15 places the immediate in result bits 31:16 and zeros in bits 15:0.
- R5: An or-immediate whose source holds a load-upper-immediate result keeps bits 31:16 unchanged and takes bits 15:0 from the immediate.
- R6: Opcode 35 (load) and opcode 43 (store) produce rs plus the sign-extended offset, with write-enable low. Load raises out_load, store raises out_store, and for both the destination field is bits 20:16.
- R7: A source register field equal to 0 reads as zero, whatever value is on the corresponding input.
- R8: When the destination is register 0, write-enable is held low while the result is still produced.
- R9: Any other opcode, or opcode 0 with any other function code, raises out_illegal and gives write-enable low, load and store low, result 0 and destination 0.
- R10: Outputs are registered and appear on the cycle after in_valid is sampled high. A cycle with in_valid low gives out_valid, write-enable, out_illegal, out_load and out_store all low on the next cycle.
- R11: A synchronous active-high reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_instr | input | 32 | Instruction word |
| in_rs_val | input | 32 | Value read for the register in bits 25:21 |
| in_rt_val | input | 32 | Value read for the register in bits 20:16 |
| out_valid | output | 1 | Result present |
| out_result | output | 32 | Result or effective address |
| out_dest | output | 5 | Destination register number |
| out_wen | output | 1 | Register write-enable |
| out_load | output | 1 | Load effective address on out_result |
| out_store | output | 1 | Store effective address on out_result |
| out_illegal | output | 1 | Unrecognised encoding |

## Verification
Every supported operation is applied across a grid of operand values: zero, one, all ones, and both ends of the signed range, so that signed and unsigned comparison give different answers and add and subtract wrap. Immediates include 0x7FFF, 0x8000 and 0xFFFF, which separate sign extension from zero extension. All 64 opcodes and all 64 function codes are swept to catch decodes that are missing or extra, and zero register fields test both the source override and the write suppression. A load-upper-immediate result is chained into an or-immediate to confirm that the two halves are kept apart.

// File: rtl/exu_pkg.sv
package exu_pkg;
    localparam int OPW   = 6;
    localparam int RIDXW = 5;
    localparam int IMMW  = 16;

    localparam logic [OPW-1:0] OP_RFMT = 6'd0;
    localparam logic [OPW-1:0] OP_ADDI = 6'd8;
    localparam logic [OPW-1:0] OP_SLTI = 6'd10;
    localparam logic [OPW-1:0] OP_ANDI = 6'd12;
    localparam logic [OPW-1:0] OP_ORI  = 6'd13;
    localparam logic [OPW-1:0] OP_LUI  = 6'd15;
    localparam logic [OPW-1:0] OP_LDW  = 6'd35;
    localparam logic [OPW-1:0] OP_STW  = 6'd43;

    localparam logic [OPW-1:0] FN_ADD = 6'd32;
    localparam logic [OPW-1:0] FN_SUB = 6'd34;
    localparam logic [OPW-1:0] FN_SLT = 6'd42;

    typedef enum logic [2:0] {
        K_ADD, K_SUB, K_SLT, K_AND, K_OR, K_LUI, K_NONE
    } alu_kind_e;

    typedef enum logic [1:0] {
        B_REG, B_SEXT, B_ZEXT
    } bsel_e;

    typedef struct packed {
        alu_kind_e             kind;
        bsel_e                 bsel;
        logic [RIDXW-1:0]      dest;
        logic [RIDXW-1:0]      src_a;
        logic [RIDXW-1:0]      src_b;
        logic [IMMW-1:0]       imm;
        logic                  wr;
        logic                  ld;
        logic                  st;
        logic                  bad;
    } dec_t;

    function automatic logic [OPW-1:0] op_of(input logic [31:0] w);
        return w[31:26];
    endfunction
endpackage

// File: rtl/exu_decode.sv
module exu_decode
    import exu_pkg::*;
(
    input  logic [31:0] instr,
    output dec_t        dec
);
    logic [OPW-1:0] op;
    logic [OPW-1:0] fn;

    assign op = op_of(instr);
    assign fn = instr[5:0];

    always_comb begin
        dec       = '0;
        dec.kind  = K_NONE;
        dec.bsel  = B_REG;
        dec.src_a = instr[25:21];
        dec.src_b = instr[20:16];
        dec.imm   = instr[15:0];
        dec.dest  = instr[20:16];
        dec.bad   = 1'b0;
        unique case (op)
            OP_RFMT: begin
                dec.dest = instr[15:11];
                dec.wr   = 1'b1;
                unique case (fn)
                    FN_ADD:  dec.kind = K_ADD;
                    FN_SUB:  dec.kind = K_SUB;
                    FN_SLT:  dec.kind = K_SLT;
                    default: begin
                        dec.wr  = 1'b0;
                        dec.bad = 1'b1;
                    end
                endcase
            end
            OP_ADDI: begin dec.kind = K_ADD; dec.bsel = B_SEXT; dec.wr = 1'b1; end
            OP_SLTI: begin dec.kind = K_SLT; dec.bsel = B_SEXT; dec.wr = 1'b1; end
            OP_ANDI: begin dec.kind = K_AND; dec.bsel = B_ZEXT; dec.wr = 1'b1; end
            OP_ORI:  begin dec.kind = K_OR;  dec.bsel = B_ZEXT; dec.wr = 1'b1; end
            OP_LUI:  begin dec.kind = K_LUI; dec.wr = 1'b1; end
            OP_LDW:  begin dec.kind = K_ADD; dec.bsel = B_SEXT; dec.ld = 1'b1; end
            OP_STW:  begin dec.kind = K_ADD; dec.bsel = B_SEXT; dec.st = 1'b1; end
            default: dec.bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/exu_operand.sv
module exu_operand
    import exu_pkg::*;
#(
    parameter int DW = 32
) (
    input  dec_t          dec,
    input  logic [DW-1:0] rs_val,
    input  logic [DW-1:0] rt_val,
    output logic [DW-1:0] opa,
    output logic [DW-1:0] opb
);
    localparam int EXTW = DW - IMMW;

    logic [DW-1:0] rt_eff;
    logic [DW-1:0] imm_s;
    logic [DW-1:0] imm_z;

    // register 0 is hard zero regardless of what the file returned (R7)
    assign opa    = (dec.src_a == '0) ? '0 : rs_val;
    assign rt_eff = (dec.src_b == '0) ? '0 : rt_val;
    assign imm_s  = {{EXTW{dec.imm[IMMW-1]}}, dec.imm};
    assign imm_z  = {{EXTW{1'b0}}, dec.imm};

    always_comb begin
        unique case (dec.bsel)
            B_SEXT:  opb = imm_s;
            B_ZEXT:  opb = imm_z;
            default: opb = rt_eff;
        endcase
    end
endmodule

// File: rtl/exu_alu.sv
module exu_alu
    import exu_pkg::*;
#(
    parameter int DW = 32
) (
    input  alu_kind_e       kind,
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   b,
    input  logic [IMMW-1:0] imm,
    output logic [DW-1:0]   y
);
    localparam int LOW = DW - IMMW;

    logic lt;
    assign lt = $signed(a) < $signed(b);

    always_comb begin
        unique case (kind)
            K_ADD:   y = a + b;
            K_SUB:   y = a - b;
            K_SLT:   y = {{(DW-1){1'b0}}, lt};
            K_AND:   y = a & b;
            K_OR:    y = a | b;
            K_LUI:   y = {imm, {LOW{1'b0}}};
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/exu_core.sv
module exu_core
    import exu_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [31:0]   in_instr,
    input  logic [DW-1:0] in_rs_val,
    input  logic [DW-1:0] in_rt_val,
    output logic          out_valid,
    output logic [DW-1:0] out_result,
    output logic [4:0]    out_dest,
    output logic          out_wen,
    output logic          out_load,
    output logic          out_store,
    output logic          out_illegal
);
    dec_t          dec;
    logic [DW-1:0] opa;
    logic [DW-1:0] opb;
    logic [DW-1:0] alu_y;

    exu_decode u_dec (.instr(in_instr), .dec(dec));

    exu_operand #(.DW(DW)) u_opnd (
        .dec(dec), .rs_val(in_rs_val), .rt_val(in_rt_val), .opa(opa), .opb(opb)
    );

    exu_alu #(.DW(DW)) u_alu (
        .kind(dec.kind), .a(opa), .b(opb), .imm(dec.imm), .y(alu_y)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_result  <= '0;
            out_dest    <= '0;
            out_wen     <= 1'b0;
            out_load    <= 1'b0;
            out_store   <= 1'b0;
            out_illegal <= 1'b0;
        end else begin
            out_valid   <= in_valid;
            out_result  <= dec.bad ? '0 : alu_y;
            out_dest    <= dec.bad ? '0 : dec.dest;
            out_wen     <= in_valid && dec.wr && (dec.dest != '0);
            out_load    <= in_valid && dec.ld;
            out_store   <= in_valid && dec.st;
            out_illegal <= in_valid && dec.bad;
        end
    end

    p_illegal_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> (!out_wen && !out_load && !out_store && out_result == '0));

    p_no_zero_write_r8: assert property (@(posedge clk) disable iff (rst)
        out_wen |-> (out_dest != '0));

    p_mem_no_wen_r6: assert property (@(posedge clk) disable iff (rst)
        (out_load || out_store) |-> !out_wen);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !out_wen && !out_illegal && !out_load && !out_store));

    p_lui_low_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_of(in_instr) == OP_LUI) |=> (out_result[15:0] == 16'h0));
endmodule

// File: tb/tb_exu_core.sv
module tb_exu_core;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] in_instr;
    logic [31:0] in_rs_val;
    logic [31:0] in_rt_val;
    logic        out_valid;
    logic [31:0] out_result;
    logic [4:0]  out_dest;
    logic        out_wen;
    logic        out_load;
    logic        out_store;
    logic        out_illegal;

    always #2.5 clk = ~clk;

    exu_core dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_instr(in_instr),
        .in_rs_val(in_rs_val), .in_rt_val(in_rt_val), .out_valid(out_valid),
        .out_result(out_result), .out_dest(out_dest), .out_wen(out_wen),
        .out_load(out_load), .out_store(out_store), .out_illegal(out_illegal)
    );

    typedef struct packed {
        logic        wen;
        logic [4:0]  dest;
        logic [31:0] res;
        logic        ill;
        logic        ld;
        logic        st;
    } exp_t;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [31:0] vals [8] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
                              32'h8000_0000, 32'h1234_5678, 32'hFFFF_8000, 32'h0000_7FFF};
    logic [15:0] imms [6] = '{16'h0, 16'h1, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234};

    function automatic exp_t model(input logic [31:0] ins, input logic [31:0] rsv, input logic [31:0] rtv);
        exp_t e;
        logic [31:0] a, b, se, ze;
        e  = '0;
        a  = (ins[25:21] == 0) ? 32'h0 : rsv;
        b  = (ins[20:16] == 0) ? 32'h0 : rtv;
        se = {{16{ins[15]}}, ins[15:0]};
        ze = {16'h0, ins[15:0]};
        e.dest = ins[20:16];
        case (ins[31:26])
            6'd0: begin
                e.dest = ins[15:11];
                case (ins[5:0])
                    6'd32:   e.res = a + b;
                    6'd34:   e.res = a - b;
                    6'd42:   e.res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
                    default: e.ill = 1'b1;
                endcase
                e.wen = !e.ill && (e.dest != 0);
            end
            6'd8:  begin e.res = a + se; e.wen = e.dest != 0; end
            6'd10: begin e.res = ($signed(a) < $signed(se)) ? 32'd1 : 32'd0; e.wen = e.dest != 0; end
            6'd12: begin e.res = a & ze; e.wen = e.dest != 0; end
            6'd13: begin e.res = a | ze; e.wen = e.dest != 0; end
            6'd15: begin e.res = {ins[15:0], 16'h0}; e.wen = e.dest != 0; end
            6'd35: begin e.res = a + se; e.ld = 1'b1; end
            6'd43: begin e.res = a + se; e.st = 1'b1; end
            default: e.ill = 1'b1;
        endcase
        if (e.ill) begin
            e.res  = 0;
            e.dest = 0;
        end
        return e;
    endfunction

    task automatic apply(input logic [31:0] ins, input logic [31:0] rsv,
                         input logic [31:0] rtv, input string req);
        exp_t e;
        e = model(ins, rsv, rtv);
        in_valid  = 1'b1;
        in_instr  = ins;
        in_rs_val = rsv;
        in_rt_val = rtv;
        @(negedge clk);
        n_chk++;
        if (!out_valid || out_wen !== e.wen || out_dest !== e.dest || out_result !== e.res ||
            out_illegal !== e.ill || out_load !== e.ld || out_store !== e.st) begin
            n_bad++;
            $display("FAIL %s instr=%h rs=%h rt=%h: got v=%b wen=%b dest=%0d res=%h ill=%b ld=%b st=%b, want v=1 wen=%b dest=%0d res=%h ill=%b ld=%b st=%b",
                     req, ins, rsv, rtv, out_valid, out_wen, out_dest, out_result, out_illegal,
                     out_load, out_store, e.wen, e.dest, e.res, e.ill, e.ld, e.st);
        end
    endtask

    function automatic logic [31:0] rword(input logic [4:0] rs, input logic [4:0] rt,
                                          input logic [4:0] rd, input logic [5:0] fn);
        return {6'd0, rs, rt, rd, 5'd3, fn};
    endfunction

    function automatic logic [31:0] iword(input logic [5:0] op, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, got timeout want completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [5:0] iops [7] = '{6'd8, 6'd10, 6'd12, 6'd13, 6'd15, 6'd35, 6'd43};
        logic [31:0] lui_res;
        rst = 1'b1; in_valid = 1'b0; in_instr = '0; in_rs_val = '0; in_rt_val = '0;
        repeat (3) @(negedge clk);
        // R11: reset state
        n_chk++;
        if (out_valid || out_wen || out_illegal || out_load || out_store ||
            out_result != 0 || out_dest != 0) begin
            n_bad++;
            $display("FAIL R11 reset: got v=%b wen=%b res=%h dest=%0d, want all 0",
                     out_valid, out_wen, out_result, out_dest);
        end
        rst = 1'b0;

        // R1 R3: register-format over operand grid
        for (int f = 0; f < 3; f++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    apply(rword(5'd5, 5'd6, 5'd7, (f == 0) ? 6'd32 : (f == 1) ? 6'd34 : 6'd42),
                          vals[i], vals[j], "R1/R3");

        // R2 R3 R4 R6: immediate-format over operands and immediates
        for (int k = 0; k < 7; k++)
            for (int i = 0; i < 8; i++)
                for (int m = 0; m < 6; m++)
                    apply(iword(iops[k], 5'd9, 5'd17, imms[m]), vals[i], 32'hDEAD_BEEF, "R2/R4/R6");

        // R7: zero source fields ignore the supplied values
        apply(rword(5'd0, 5'd6, 5'd7, 6'd32), 32'h5555_5555, 32'h10, "R7");
        apply(rword(5'd5, 5'd0, 5'd7, 6'd34), 32'h20, 32'h7777_7777, "R7");
        apply(iword(6'd8, 5'd0, 5'd3, 16'hFFFE), 32'h1000, 32'h0, "R7");
        apply(iword(6'd43, 5'd0, 5'd3, 16'h0040), 32'hABCD_0000, 32'h0, "R7");

        // R8: destination register 0 suppresses the write
        apply(rword(5'd5, 5'd6, 5'd0, 6'd32), 32'h3, 32'h4, "R8");
        apply(iword(6'd13, 5'd5, 5'd0, 16'h00F0), 32'h1, 32'h0, "R8");
        apply(iword(6'd15, 5'd5, 5'd0, 16'hBEEF), 32'h1, 32'h0, "R8");

        // R5: load-upper then or-immediate chained through the result
        apply(iword(6'd15, 5'd0, 5'd8, 16'hAAAA), 32'h0, 32'h0, "R5");
        lui_res = out_result;
        apply(iword(6'd13, 5'd8, 5'd8, 16'h5A5A), lui_res, 32'h0, "R5");
        n_chk++;
        if (out_result !== 32'hAAAA_5A5A) begin
            n_bad++;
            $display("FAIL R5 chain: got %h want aaaa5a5a", out_result);
        end

        // R9: every opcode and every function code
        for (int op = 0; op < 64; op++)
            apply(iword(6'(op), 5'd2, 5'd4, 16'h1357), 32'h0F0F_0F0F, 32'h0000_0101, "R9");
        for (int fn = 0; fn < 64; fn++)
            apply(rword(5'd2, 5'd4, 5'd6, 6'(fn)), 32'h0F0F_0F0F, 32'h0000_0101, "R9");

        // R10: idle cycle after a writing op, then after an illegal op
        apply(rword(5'd1, 5'd2, 5'd3, 6'd32), 32'h1, 32'h2, "R10");
        in_valid = 1'b0;
        @(negedge clk);
        n_chk++;
        if (out_valid || out_wen || out_illegal || out_load || out_store) begin
            n_bad++;
            $display("FAIL R10 idle: got v=%b wen=%b ill=%b ld=%b st=%b want all 0",
                     out_valid, out_wen, out_illegal, out_load, out_store);
        end
        apply(iword(6'd63, 5'd1, 5'd2, 16'h0), 32'h1, 32'h2, "R10");
        in_valid = 1'b0;
        in_instr = iword(6'd35, 5'd1, 5'd2, 16'h4);
        @(negedge clk);
        n_chk++;
        if (out_valid || out_wen || out_illegal || out_load || out_store) begin
            n_bad++;
            $display("FAIL R10 idle2: got v=%b wen=%b ill=%b ld=%b st=%b want all 0",
                     out_valid, out_wen, out_illegal, out_load, out_store);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule